// File: doc/BRIEF.md
# Scan-Aligned Sample Buffer with Interrupt

This block sits between an A/D conversion sequencer and a byte-wide host register port. Each converted 16-bit sample is pushed into an on-chip FIFO. The host reads each sample as two bytes: first the low byte, then the high byte. The two bytes always belong to the same sample because the high byte is captured at the moment the low byte is read.

The block keeps four status flags. The empty and half-full flags form the main status view. The overflow and underflow flags are sticky error indications that the host reads on a secondary status page.

An interrupt request is raised only at the end of a multi-channel scan, and only when the FIFO already holds at least half its capacity. The FIFO therefore holds a whole number of scans when the host is called. An interrupt service routine can then drain at least half a FIFO of complete scans in each call.

Top module: `scan_fifo_irq`

## Requirements
- R1: After reset, the block shows empty=1, half=0, ovf=0, udf=0 and irq=0.
- R2: `flag_empty` is 1 exactly when the FIFO holds zero samples. It updates in the cycle after the push or pop edge.
- R3: `flag_half` is 1 exactly when the FIFO holds at least DEPTH/2 samples (256 with defaults).
- R4: A `rd_lo` strobe on a non-empty FIFO returns bits [7:0] of the oldest sample on `rd_data` in the next cycle, and captures bits [15:8]. A following `rd_hi` strobe returns the captured byte and removes the sample. Samples come out in write order.
- R5: A sample write while the FIFO holds DEPTH samples is dropped and sets `flag_ovf`. The flag stays set until `fifo_clr`.
- R6: A `rd_lo` or `rd_hi` strobe while the FIFO is empty sets `flag_udf` and returns 0 on `rd_data`, with no change to the contents. The flag stays set until `fifo_clr`.
- R7: `irq` rises only in the cycle after a rising edge of `scan_done` that occurs while `flag_half` is 1. A scan edge while the flag is 0 leaves `irq` low.
- R8: Once set, `irq` stays high until `irq_ack` or `fifo_clr`. If `irq_ack` and a scan edge arrive in the same cycle, the acknowledge wins.
- R9: Holding `scan_done` high for several cycles counts as one scan boundary. After an acknowledge, `irq` does not set again until `scan_done` has gone low and risen again.
- R10: `fifo_clr` empties the FIFO and clears ovf, udf and irq on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_wr | input | 1 | Sample write strobe |
| smp_data | input | 16 | Sample to store |
| scan_done | input | 1 | End-of-scan indication; rising edge is the boundary |
| rd_lo | input | 1 | Host read of low byte (captures high byte) |
| rd_hi | input | 1 | Host read of high byte (removes sample) |
| fifo_clr | input | 1 | Synchronous FIFO clear |
| irq_ack | input | 1 | Interrupt acknowledge |
| rd_data | output | 8 | Byte returned by the last host read |
| flag_empty | output | 1 | FIFO holds no samples |
| flag_half | output | 1 | FIFO at least half full |
| flag_ovf | output | 1 | Sticky overflow (secondary page) |
| flag_udf | output | 1 | Sticky underflow (secondary page) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for these rules:
- the overflow and underflow flags stay set once set;
- an interrupt rises only after a scan edge seen while half full;
- the request holds until acknowledged;
- a clear leaves every flag at rest.

Other behaviour can only be shown by the bench scenarios, which compare against a queue model:
- the order of the byte pairs;
- the exact threshold of the half flag;
- dropping of writes when full;
- suppression of re-firing while `scan_done` stays high.

// File: rtl/scan_fifo_pkg.sv
package scan_fifo_pkg;
  localparam int SMP_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [SMP_W-1:0]  sample_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sample_store.sv
module sample_store #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  scan_fifo_pkg::sample_t din,
  input  logic                   pop,
  output scan_fifo_pkg::sample_t head,
  output logic [CW-1:0]          level,
  output logic                   is_empty,
  output logic                   is_full
);
  import scan_fifo_pkg::*;

  sample_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [CW-1:0] level_nxt;
  logic          wr_en, rd_en;

  assign is_empty = (level == '0);
  assign is_full  = (level == CW'(DEPTH));
  assign head     = mem[rd_ptr];

  always_comb begin
    wr_en      = push & ~is_full;
    rd_en      = pop & ~is_empty;
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    level_nxt  = level;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      level_nxt  = '0;
    end else begin
      if (wr_en) wr_ptr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr_nxt = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level_nxt = level + 1'b1;
        2'b01:   level_nxt = level - 1'b1;
        default: level_nxt = level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      level  <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/byte_pair_port.sv
module byte_pair_port (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_lo,
  input  logic                   rd_hi,
  input  scan_fifo_pkg::sample_t head,
  input  logic                   is_empty,
  output logic                   pop,
  output logic                   udf_evt,
  output scan_fifo_pkg::byte_t   rd_data
);
  import scan_fifo_pkg::*;

  byte_t hi_hold, hi_hold_nxt, rd_data_nxt;
  logic  any_rd;

  always_comb begin
    any_rd      = rd_lo | rd_hi;
    pop         = rd_hi & ~is_empty;
    udf_evt     = any_rd & is_empty;
    hi_hold_nxt = hi_hold;
    rd_data_nxt = rd_data;
    if (any_rd && is_empty) begin
      rd_data_nxt = '0;
    end else if (rd_hi) begin
      rd_data_nxt = hi_hold;
    end else if (rd_lo) begin
      rd_data_nxt = head[BYTE_W-1:0];
      hi_hold_nxt = head[SMP_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hold <= '0;
      rd_data <= '0;
    end else if (any_rd) begin
      hi_hold <= hi_hold_nxt;
      rd_data <= rd_data_nxt;
    end
  end
endmodule

// File: rtl/scan_irq_gate.sv
module scan_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scan_done,
  input  logic half,
  input  logic ack,
  output logic irq
);
  logic scan_q, irq_nxt, scan_edge;

  always_comb begin
    scan_edge = scan_done & ~scan_q;
    irq_nxt   = irq;
    if (clr || ack)             irq_nxt = 1'b0;
    else if (scan_edge && half) irq_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      scan_q <= scan_done;
      irq    <= irq_nxt;
    end
  end
endmodule

// File: rtl/scan_fifo_irq.sv
module scan_fifo_irq #(
  parameter int DEPTH = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_wr,
  input  logic [15:0] smp_data,
  input  logic       scan_done,
  input  logic       rd_lo,
  input  logic       rd_hi,
  input  logic       fifo_clr,
  input  logic       irq_ack,
  output logic [7:0] rd_data,
  output logic       flag_empty,
  output logic       flag_half,
  output logic       flag_ovf,
  output logic       flag_udf,
  output logic       irq
);
  import scan_fifo_pkg::*;

  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  sample_t       head;
  logic [CW-1:0] level;
  logic          is_empty, is_full, pop, udf_evt;
  logic          ovf_nxt, udf_nxt;

  sample_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (fifo_clr),
    .push     (smp_wr),
    .din      (smp_data),
    .pop      (pop),
    .head     (head),
    .level    (level),
    .is_empty (is_empty),
    .is_full  (is_full)
  );

  byte_pair_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .head     (head),
    .is_empty (is_empty),
    .pop      (pop),
    .udf_evt  (udf_evt),
    .rd_data  (rd_data)
  );

  assign flag_empty = is_empty;
  assign flag_half  = (level >= CW'(HALF));

  scan_irq_gate u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .scan_done (scan_done),
    .half      (flag_half),
    .ack       (irq_ack),
    .irq       (irq)
  );

  always_comb begin
    ovf_nxt = flag_ovf | (smp_wr & is_full);
    udf_nxt = flag_udf | udf_evt;
    if (fifo_clr) begin
      ovf_nxt = 1'b0;
      udf_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ovf <= 1'b0;
      flag_udf <= 1'b0;
    end else begin
      flag_ovf <= ovf_nxt;
      flag_udf <= udf_nxt;
    end
  end
endmodule

// File: rtl/scan_fifo_irq_checker.sv
module scan_fifo_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_wr,
  input logic scan_done,
  input logic rd_lo,
  input logic rd_hi,
  input logic fifo_clr,
  input logic irq_ack,
  input logic flag_empty,
  input logic flag_half,
  input logic flag_ovf,
  input logic flag_udf,
  input logic irq
);
  // R2: the FIFO becomes empty only after a read-and-remove or a clear
  assert_empty_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_empty) |-> $past(rd_hi || fifo_clr));

  // R5: overflow is sticky and begins only with a write
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf && !fifo_clr |=> flag_ovf);
  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> $past(smp_wr));

  // R6: underflow is sticky and begins only with a host read
  assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_udf && !fifo_clr |=> flag_udf);
  assert_udf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_udf) |-> $past((rd_lo || rd_hi) && flag_empty));

  // R7: the request rises only on a scan edge seen while half full
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scan_done && flag_half && !irq_ack));

  // R8: the request holds until acknowledged or cleared
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_ack && !fifo_clr |=> irq);

  // R10: a clear leaves every indication at rest
  assert_clear_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> flag_empty && !flag_half && !flag_ovf && !flag_udf && !irq);
endmodule

bind scan_fifo_irq scan_fifo_irq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_wr     (smp_wr),
  .scan_done  (scan_done),
  .rd_lo      (rd_lo),
  .rd_hi      (rd_hi),
  .fifo_clr   (fifo_clr),
  .irq_ack    (irq_ack),
  .flag_empty (flag_empty),
  .flag_half  (flag_half),
  .flag_ovf   (flag_ovf),
  .flag_udf   (flag_udf),
  .irq        (irq)
);

// File: tb/scan_fifo_irq_test.sv
module scan_fifo_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_wr = 1'b0, scan_done = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic        fifo_clr = 1'b0, irq_ack = 1'b0;
  logic [15:0] smp_data = '0;
  logic [7:0]  rd_data;
  logic        flag_empty, flag_half, flag_ovf, flag_udf, irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [15:0] m_q[$];
  logic [7:0]  m_hold = '0, m_rd = '0;
  bit          m_ovf = 0, m_udf = 0, m_irq = 0, m_scan_q = 0, m_rd_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_fifo_irq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .smp_wr(smp_wr), .smp_data(smp_data),
    .scan_done(scan_done), .rd_lo(rd_lo), .rd_hi(rd_hi), .fifo_clr(fifo_clr),
    .irq_ack(irq_ack), .rd_data(rd_data), .flag_empty(flag_empty),
    .flag_half(flag_half), .flag_ovf(flag_ovf), .flag_udf(flag_udf), .irq(irq)
  );

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_half();
    return m_q.size() >= HALF;
  endfunction

  task automatic check_all();
    expect_eq("R2 empty", flag_empty, m_q.size() == 0);
    expect_eq("R3 half", flag_half, model_half());
    expect_eq("R5 ovf", flag_ovf, m_ovf);
    expect_eq("R6 udf", flag_udf, m_udf);
    expect_eq("R7/R8/R9 irq", irq, m_irq);
    if (m_rd_chk) expect_eq("R4 rd_data", rd_data, m_rd);
  endtask

  // apply one cycle of stimulus, advance the model, check after the edge
  task automatic cycle(input bit w, input logic [15:0] d, input bit s,
                       input bit lo, input bit hi, input bit c, input bit a);
    int n;
    bit edge_s;
    smp_wr = w; smp_data = d; scan_done = s; rd_lo = lo; rd_hi = hi;
    fifo_clr = c; irq_ack = a;
    n = m_q.size();
    m_rd_chk = lo | hi;
    if (c) begin
      m_q.delete();
      m_ovf = 0; m_udf = 0; m_irq = 0;
      if (lo | hi) m_rd_chk = 0;
    end else begin
      edge_s = s && !m_scan_q;
      if (a) m_irq = 0;
      else if (edge_s && n >= HALF) m_irq = 1;
      if ((lo || hi) && n == 0) begin
        m_udf = 1; m_rd = 8'h00;
      end else if (hi) begin
        m_rd = m_hold;
        void'(m_q.pop_front());
      end else if (lo) begin
        m_rd = m_q[0][7:0];
        m_hold = m_q[0][15:8];
      end
      if (w) begin
        if (n == DEPTH) m_ovf = 1;
        else m_q.push_back(d);
      end
    end
    m_scan_q = s;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    cycle(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_pair();
    cycle(0, '0, 0, 1, 0, 0, 0);
    cycle(0, '0, 0, 0, 1, 0, 0);
  endtask

  task automatic write_one();
    cycle(1, 16'($urandom), 0, 0, 0, 0, 0);
  endtask

  // one scan: several samples then a scan_done held 1..3 cycles (R9)
  task automatic do_scan(input int len);
    int hold;
    for (int i = 0; i < len; i++) begin
      write_one();
      if ($urandom_range(3) == 0) idle();
    end
    hold = $urandom_range(3, 1);
    for (int i = 0; i < hold; i++) cycle(0, '0, 1, 0, 0, 0, 0);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 empty", flag_empty, 1);
    expect_eq("R1 half", flag_half, 0);
    expect_eq("R1 ovf", flag_ovf, 0);
    expect_eq("R1 udf", flag_udf, 0);
    expect_eq("R1 irq", irq, 0);

    // R6: read from empty sets underflow and returns zero
    cycle(0, '0, 0, 1, 0, 0, 0);
    cycle(0, '0, 0, 0, 1, 0, 0);
    // R10: clear resets it
    cycle(0, '0, 0, 0, 0, 1, 0);
    idle();

    // R7: scan below the threshold must not raise irq
    do_scan(8);
    repeat (8) read_pair();

    // random scans with service when irq is seen (R4, R7, R8, R9)
    for (int s = 0; s < 120; s++) begin
      do_scan($urandom_range(16, 4));
      if (m_irq) begin
        // R9: keep scan_done high after ack, no re-fire
        cycle(0, '0, 1, 0, 0, 0, 1);
        cycle(0, '0, 1, 0, 0, 0, 0);
        idle();
        while (m_q.size() >= HALF / 2) read_pair();
      end else if ($urandom_range(4) == 0) begin
        read_pair();
      end
    end

    // R8: ack and scan edge in the same cycle; ack wins
    cycle(0, '0, 0, 0, 0, 1, 0);
    for (int i = 0; i < HALF; i++) write_one();
    cycle(0, '0, 1, 0, 0, 0, 1);
    idle();
    cycle(0, '0, 1, 0, 0, 0, 0);
    repeat (4) idle();

    // R5: fill to full and past it
    for (int i = m_q.size(); i < DEPTH + 3; i++) write_one();
    // simultaneous write while full with a pop: write still dropped
    cycle(0, '0, 0, 1, 0, 0, 0);
    cycle(1, 16'hBEEF, 0, 0, 1, 0, 0);
    repeat (20) read_pair();

    // R10: clear with data, flags and irq all set
    cycle(0, '0, 0, 0, 0, 1, 0);
    idle();
    // R6 hi-only read on empty
    cycle(0, '0, 0, 0, 1, 0, 0);
    cycle(0, '0, 0, 0, 0, 1, 0);
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule